// File: doc/BRIEF.md
# Shared-Resource Integer ALU

A combinational 32-bit integer arithmetic and logic unit for the execute stage of a simple RISC-style pipeline. It takes a first operand (always a register value), a second operand (a register value or an already extended immediate) and a 4-bit operation code. It returns one 32-bit result in the same cycle. All thirteen operations are served by three shared datapath pieces: one carry-in adder, one arithmetic right shifter and one bitwise logic unit. A final selector picks the adder sum, a zero-extended compare bit, the shifter output or the logic output.

Subtraction and every less-than compare use the single adder. The second operand is inverted and the carry-in is set. For the immediate compare forms the two operands are swapped and the carry-in is cleared. The adder then forms imm − (reg + 1), so a non-negative sum means the register value is below the immediate. The adder is one bit wider than the operands. Signed operations fill that extra bit from the sign, and unsigned operations fill it with zero. In both cases the top bit of the sum tells whether the true difference is negative. For unsigned operations this top bit is the inverse of the carry out of the 32-bit sum.

Left shifts reverse the operand, shift right and reverse the result back. Logical right shifts force the fill bit to zero.

Top module: `shared_alu`

## Requirements
- R1: Op code 0 (add) gives y = a + b modulo 2^32.
- R2: Op code 1 (subtract) gives y = a − b modulo 2^32.
- R3: Op code 2 (signed register compare) gives y = 1 when a < b as two's-complement numbers, else 0. For example −1 < 1 gives 1 and 0x7FFFFFFF < 0x80000000 gives 0.
- R4: Op code 3 (unsigned register compare) gives y = 1 when a < b as unsigned numbers, else 0. For example 0 < 0xFFFFFFFF gives 1 and equal operands give 0.
- R5: Op code 4 (signed immediate compare) gives y = 1 when the register operand a is below the immediate b as signed numbers, else 0. Equal values give 0.
- R6: Op code 5 (unsigned immediate compare) gives y = 1 when a is below b as unsigned numbers, else 0. Equal values give 0.
- R7: Op code 6 shifts a left by b[4:0] places, filling with zeros.
- R8: Op code 7 shifts a right by b[4:0] places, filling with zeros.
- R9: Op code 8 shifts a right by b[4:0] places, filling with a[31].
- R10: Op codes 9, 10, 11 and 12 give the bitwise AND, OR, XOR and NOR of a and b.
- R11: For the three shifts, only b[4:0] is used. A shift amount of 0 returns a unchanged, and bits b[31:5] have no effect.
- R12: Op codes 13, 14 and 15 give y = 0.
- R13: Every compare result has bits 31:1 equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code (see requirements for the encoding) |
| a | input | 32 | First operand, always the register value |
| b | input | 32 | Second operand: register value, immediate, or shift amount in bits 4:0 |
| y | output | 32 | Result |

## Verification
The hardest cases to reach from the ports are the ones where the sign of the 33-bit adder sum disagrees with what a 32-bit adder would report. These arise in signed compares with operands of opposite sign, and in unsigned compares whose operands straddle 0x80000000. In the immediate forms they also combine with the one-off offset, where equal operands must still give 0. The vector table places operands at exactly these boundaries: −1 against 1, 0x7FFFFFFF against 0x80000000, 0 against 0xFFFFFFFF, and equal pairs. It also includes shift amounts whose upper bits are set while their low five bits are zero. A long pseudo-random sweep over all sixteen op codes then compares every result against a behavioural model.

// File: rtl/shared_alu_pkg.sv
package shared_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUB   = 4'd1,
      OP_SLT   = 4'd2,
      OP_SLTU  = 4'd3,
      OP_SLTI  = 4'd4,
      OP_SLTIU = 4'd5,
      OP_SHL   = 4'd6,
      OP_SHRL  = 4'd7,
      OP_SHRA  = 4'd8,
      OP_AND   = 4'd9,
      OP_OR    = 4'd10,
      OP_XOR   = 4'd11,
      OP_NOR   = 4'd12
   } alu_op_e;

   typedef enum logic [1:0] {
      LF_AND = 2'd0,
      LF_OR  = 2'd1,
      LF_XOR = 2'd2,
      LF_NOR = 2'd3
   } logic_fn_e;

   typedef enum logic [1:0] {
      SEL_SUM   = 2'd0,
      SEL_CMP   = 2'd1,
      SEL_SHIFT = 2'd2,
      SEL_LOGIC = 2'd3
   } out_sel_e;

   typedef struct packed {
      logic      swap;      // adder x = b, y = a
      logic      inv_y;     // invert adder second input
      logic      cin;       // adder carry-in
      logic      sgn;       // sign-extend into guard bit
      logic      cmp_flip;  // compare bit = ~negative
      logic      shl;       // left shift via reversal
      logic      arith;     // replicate sign on right shift
      logic_fn_e lfn;
      out_sel_e  sel;
      logic      zero;      // unused code: force zero
   } alu_ctl_t;

endpackage

// File: rtl/shared_alu_dec.sv
module shared_alu_dec
   import shared_alu_pkg::*;
(
   input  logic [3:0] op,
   output alu_ctl_t   ctl
);

   always_comb begin
      ctl          = '0;
      ctl.lfn      = LF_AND;
      ctl.sel      = SEL_SUM;
      case (op)
         OP_ADD:   ctl.sel = SEL_SUM;
         OP_SUB: begin
            ctl.inv_y = 1'b1;
            ctl.cin   = 1'b1;
         end
         OP_SLT: begin
            ctl.inv_y = 1'b1;
            ctl.cin   = 1'b1;
            ctl.sgn   = 1'b1;
            ctl.sel   = SEL_CMP;
         end
         OP_SLTU: begin
            ctl.inv_y = 1'b1;
            ctl.cin   = 1'b1;
            ctl.sel   = SEL_CMP;
         end
         OP_SLTI: begin
            ctl.swap     = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.sgn      = 1'b1;
            ctl.cmp_flip = 1'b1;
            ctl.sel      = SEL_CMP;
         end
         OP_SLTIU: begin
            ctl.swap     = 1'b1;
            ctl.inv_y    = 1'b1;
            ctl.cmp_flip = 1'b1;
            ctl.sel      = SEL_CMP;
         end
         OP_SHL: begin
            ctl.shl = 1'b1;
            ctl.sel = SEL_SHIFT;
         end
         OP_SHRL:  ctl.sel = SEL_SHIFT;
         OP_SHRA: begin
            ctl.arith = 1'b1;
            ctl.sel   = SEL_SHIFT;
         end
         OP_AND: begin
            ctl.lfn = LF_AND;
            ctl.sel = SEL_LOGIC;
         end
         OP_OR: begin
            ctl.lfn = LF_OR;
            ctl.sel = SEL_LOGIC;
         end
         OP_XOR: begin
            ctl.lfn = LF_XOR;
            ctl.sel = SEL_LOGIC;
         end
         OP_NOR: begin
            ctl.lfn = LF_NOR;
            ctl.sel = SEL_LOGIC;
         end
         default:  ctl.zero = 1'b1;
      endcase
   end

endmodule

// File: rtl/shared_alu_adder.sv
module shared_alu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             inv_y,
   input  logic             cin,
   input  logic             sgn,
   output logic [WIDTH-1:0] sum,
   output logic             neg
);

   localparam int EW = WIDTH + 1;

   logic [EW-1:0] x_e;
   logic [EW-1:0] y_e;
   logic [EW-1:0] y_op;
   logic [EW-1:0] s_e;

   assign x_e  = {sgn & x[WIDTH-1], x};
   assign y_e  = {sgn & y[WIDTH-1], y};
   assign y_op = inv_y ? ~y_e : y_e;
   assign s_e  = x_e + y_op + {{(EW-1){1'b0}}, cin};
   assign sum  = s_e[WIDTH-1:0];
   assign neg  = s_e[EW-1];

endmodule

// File: rtl/shared_alu_shifter.sv
module shared_alu_shifter #(
   parameter int WIDTH      = 32,
   parameter int STAGED     = 1,
   localparam int AMT_W     = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] d,
   input  logic [AMT_W-1:0] amt,
   input  logic             shl,
   input  logic             arith,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] d_rev;
   logic [WIDTH-1:0] sh_in;
   logic [WIDTH-1:0] sh_out;
   logic [WIDTH-1:0] out_rev;
   logic             fill;

   for (genvar i = 0; i < WIDTH; i++) begin : g_rev
      assign d_rev[i]   = d[WIDTH-1-i];
      assign out_rev[i] = sh_out[WIDTH-1-i];
   end

   assign sh_in = shl ? d_rev : d;
   assign fill  = arith & ~shl & d[WIDTH-1];

   if (STAGED != 0) begin : g_staged
      logic [WIDTH-1:0] stage [AMT_W+1];
      assign stage[0] = sh_in;
      for (genvar s = 0; s < AMT_W; s++) begin : g_stage
         localparam int DIST = 1 << s;
         assign stage[s+1] = amt[s]
            ? {{DIST{fill}}, stage[s][WIDTH-1:DIST]}
            : stage[s];
      end
      assign sh_out = stage[AMT_W];
   end else begin : g_flat
      logic signed [WIDTH:0] wide;
      logic [WIDTH:0]        shifted;
      assign wide    = $signed({fill, sh_in});
      assign shifted = wide >>> amt;
      assign sh_out  = shifted[WIDTH-1:0];
   end

   assign q = shl ? out_rev : sh_out;

endmodule

// File: rtl/shared_alu_logic.sv
module shared_alu_logic
   import shared_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic_fn_e        fn,
   output logic [WIDTH-1:0] q
);

   always_comb begin
      case (fn)
         LF_AND:  q = a & b;
         LF_OR:   q = a | b;
         LF_XOR:  q = a ^ b;
         default: q = ~(a | b);
      endcase
   end

endmodule

// File: rtl/shared_alu.sv
module shared_alu
   import shared_alu_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter int STAGED_SHIFT = 1
) (
   input  logic [3:0]       op,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);

   localparam int AMT_W = $clog2(WIDTH);

   if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
      $error("shared_alu: WIDTH must be a power of two of at least 2");
   end

   alu_ctl_t         ctl;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic [WIDTH-1:0] sum;
   logic             neg;
   logic             cmp_bit;
   logic [WIDTH-1:0] sh_q;
   logic [WIDTH-1:0] lg_q;

   shared_alu_dec u_dec (
      .op  (op),
      .ctl (ctl)
   );

   assign add_x = ctl.swap ? b : a;
   assign add_y = ctl.swap ? a : b;

   shared_alu_adder #(.WIDTH(WIDTH)) u_add (
      .x     (add_x),
      .y     (add_y),
      .inv_y (ctl.inv_y),
      .cin   (ctl.cin),
      .sgn   (ctl.sgn),
      .sum   (sum),
      .neg   (neg)
   );

   assign cmp_bit = neg ^ ctl.cmp_flip;

   shared_alu_shifter #(.WIDTH(WIDTH), .STAGED(STAGED_SHIFT)) u_sh (
      .d     (a),
      .amt   (b[AMT_W-1:0]),
      .shl   (ctl.shl),
      .arith (ctl.arith),
      .q     (sh_q)
   );

   shared_alu_logic #(.WIDTH(WIDTH)) u_lg (
      .a  (a),
      .b  (b),
      .fn (ctl.lfn),
      .q  (lg_q)
   );

   always_comb begin
      case (ctl.sel)
         SEL_SUM:   y = sum;
         SEL_CMP:   y = {{(WIDTH-1){1'b0}}, cmp_bit};
         SEL_SHIFT: y = sh_q;
         default:   y = lg_q;
      endcase
      if (ctl.zero) y = '0;
   end

endmodule

// File: rtl/shared_alu_chk.sv
module shared_alu_chk
   import shared_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input logic [3:0]       op,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic [WIDTH-1:0] y
);

   localparam int AMT_W = $clog2(WIDTH);

   logic is_cmp;
   logic is_shift;
   assign is_cmp   = (op == OP_SLT) || (op == OP_SLTU) ||
                     (op == OP_SLTI) || (op == OP_SLTIU);
   assign is_shift = (op == OP_SHL) || (op == OP_SHRL) || (op == OP_SHRA);

   always_comb begin
      assert_sub_R2: assert (op != OP_SUB || y == a - b)
         else $error("sub mismatch");
      assert_slt_R3: assert (op != OP_SLT ||
                             y[0] == ($signed(a) < $signed(b)))
         else $error("signed compare mismatch");
      assert_sltiu_R6: assert (op != OP_SLTIU || y[0] == (a < b))
         else $error("unsigned immediate compare mismatch");
      assert_shift_zero_R11: assert (!is_shift || b[AMT_W-1:0] != '0 || y == a)
         else $error("zero shift changed operand");
      assert_unused_R12: assert (op < 4'd13 || y == '0)
         else $error("unused op code gave nonzero result");
      assert_cmp_upper_R13: assert (!is_cmp || y[WIDTH-1:1] == '0)
         else $error("compare upper bits set");
   end

endmodule

bind shared_alu shared_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op (op),
   .a  (a),
   .b  (b),
   .y  (y)
);

// File: tb/sim_shared_alu.sv
module sim_shared_alu;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op;
   logic [31:0] a;
   logic [31:0] b;
   logic [31:0] y;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   shared_alu u0 (.op(op), .a(a), .b(b), .y(y));

   // {req, op, a, b, expected}
   localparam int NV = 33;
   localparam logic [103:0] VEC [NV] = '{
      {4'd1,  4'd0,  32'h00000005, 32'h00000007, 32'h0000000C}, // R1
      {4'd1,  4'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R1 wrap
      {4'd2,  4'd1,  32'h00000003, 32'h00000005, 32'hFFFFFFFE}, // R2
      {4'd2,  4'd1,  32'h80000000, 32'h00000001, 32'h7FFFFFFF}, // R2
      {4'd3,  4'd2,  32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R3 -1<1
      {4'd3,  4'd2,  32'h7FFFFFFF, 32'h80000000, 32'h00000000}, // R3
      {4'd3,  4'd2,  32'h00000005, 32'h00000005, 32'h00000000}, // R3 equal
      {4'd4,  4'd3,  32'h00000000, 32'hFFFFFFFF, 32'h00000001}, // R4
      {4'd4,  4'd3,  32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R4
      {4'd4,  4'd3,  32'h00000009, 32'h00000009, 32'h00000000}, // R4 equal
      {4'd5,  4'd4,  32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000001}, // R5 -2<-1
      {4'd5,  4'd4,  32'h00000001, 32'hFFFFFFFF, 32'h00000000}, // R5
      {4'd5,  4'd4,  32'h00000006, 32'h00000006, 32'h00000000}, // R5 equal
      {4'd6,  4'd5,  32'h00000003, 32'h00000004, 32'h00000001}, // R6
      {4'd6,  4'd5,  32'h00000004, 32'h00000004, 32'h00000000}, // R6 equal
      {4'd6,  4'd5,  32'h00000000, 32'hFFFFFFFF, 32'h00000001}, // R6
      {4'd6,  4'd5,  32'hFFFFFFFF, 32'h00000000, 32'h00000000}, // R6
      {4'd7,  4'd6,  32'h00000001, 32'h0000001F, 32'h80000000}, // R7
      {4'd7,  4'd6,  32'h0000F00F, 32'h00000004, 32'h000F00F0}, // R7
      {4'd8,  4'd7,  32'h80000000, 32'h0000001F, 32'h00000001}, // R8
      {4'd8,  4'd7,  32'hF0000000, 32'h00000004, 32'h0F000000}, // R8
      {4'd9,  4'd8,  32'hF0000000, 32'h00000004, 32'hFF000000}, // R9
      {4'd9,  4'd8,  32'h70000000, 32'h00000004, 32'h07000000}, // R9
      {4'd9,  4'd8,  32'h80000000, 32'h0000001F, 32'hFFFFFFFF}, // R9
      {4'd10, 4'd9,  32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R10 and
      {4'd10, 4'd10, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0}, // R10 or
      {4'd10, 4'd11, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0}, // R10 xor
      {4'd10, 4'd12, 32'hF0F0F0F0, 32'hFF00FF00, 32'h000F000F}, // R10 nor
      {4'd11, 4'd6,  32'h12345678, 32'h00000000, 32'h12345678}, // R11
      {4'd11, 4'd8,  32'h87654321, 32'h00000020, 32'h87654321}, // R11
      {4'd11, 4'd7,  32'h80000000, 32'h00000021, 32'h40000000}, // R11
      {4'd12, 4'd13, 32'h00000005, 32'h00000007, 32'h00000000}, // R12
      {4'd12, 4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000}  // R12
   };

   function automatic logic [31:0] model(input logic [3:0] o,
                                         input logic [31:0] x,
                                         input logic [31:0] z);
      case (o)
         4'd0:        return x + z;
         4'd1:        return x - z;
         4'd2, 4'd4:  return {31'b0, $signed(x) < $signed(z)};
         4'd3, 4'd5:  return {31'b0, x < z};
         4'd6:        return x << z[4:0];
         4'd7:        return x >> z[4:0];
         4'd8:        return $signed(x) >>> z[4:0];
         4'd9:        return x & z;
         4'd10:       return x | z;
         4'd11:       return x ^ z;
         4'd12:       return ~(x | z);
         default:     return 32'h0;
      endcase
   endfunction

   task automatic apply(input logic [3:0] o, input logic [31:0] x,
                        input logic [31:0] z, input logic [31:0] exp,
                        input string req);
      @(negedge clk);
      op = o; a = x; b = z;
      #2;
      checks++;
      if (y !== exp) begin
         errors++;
         $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h",
                  req, o, x, z, y, exp);
      end
   endtask

   initial begin
      logic [31:0] st;
      op = 4'd0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: zero inputs give zero sum (R1)
      apply(4'd0, 32'h0, 32'h0, 32'h0, "R1 reset");
      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][99:96], VEC[i][95:64], VEC[i][63:32], VEC[i][31:0],
               $sformatf("R%0d", VEC[i][103:100]));
      end
      // compare results keep bits 31:1 clear (R13)
      apply(4'd3, 32'h00000001, 32'hFFFFFFFE, 32'h00000001, "R13");
      // upper shift amount bits ignored (R11)
      apply(4'd6, 32'h00000003, 32'hFFFFFFE1, 32'h00000006, "R11 upper");
      st = 32'hACE1_2468;
      for (int i = 0; i < 400; i++) begin
         logic [31:0] ra;
         logic [31:0] rb;
         logic [3:0]  ro;
         st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
         ra = st;
         st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
         rb = (i % 4 == 0) ? ra + {31'b0, st[0]} : st;
         ro = st[11:8];
         apply(ro, ra, rb, model(ro, ra, rb), "R1..R12 sweep");
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule